// File: doc/BRIEF.md
# Key-Protected Configuration Lock Controller

This block guards write access to a bank of configuration registers that sit on a simple register bus. The bus carries an address, write data, a write strobe and read data. Two addresses belong to the block itself: a key register and a control register. A window of further addresses belongs to the protected bank. For each slot in that window the block produces a write enable, and it raises that enable only while a configuration session is open.

A session opens when the unlock key is written to the key register. It closes when any other value is written there. After a hard reset only one session is allowed. The only exception is a reconfiguration bit in the control register. If that bit is set when a session closes, a later unlock may open a new session. If it is clear when a session closes, the lock becomes permanent until the next hard reset. The control register also shows the current lock status as a read-only bit.

Reads are never gated by the block. The protected bank serves its own read data. The block drives read data only for its two registers and returns zero for every other address.

Top module: `cfg_lock_guard`

## Requirements
- R1: After hard reset the lock output is 1, the reconfiguration output is 0 and no protected write enable is active.
- R2: A read of the key register (address 0) always returns 16'h96A5. A read of the control register (address 1) returns the lock status in bit 0 and the reconfiguration bit in bit 1, with all other bits zero. Every other address reads as zero.
- R3: Writing 16'h2D52 to the key register while in the fresh post-reset state opens a session: the lock output reads 0 from the next cycle.
- R4: While a session is open, a write strobe to protected address 2+i raises bit i of the write-enable vector in the same cycle, and no other bit. While locked, no bit is ever raised. The protected window covers addresses 2 to 9.
- R5: Writing any value other than 16'h2D52 to the key register while a session is open closes it: the lock output reads 1 from the next cycle.
- R6: If the reconfiguration bit is 0 when a session closes, later writes of 16'h2D52 are ignored and the block stays locked until hard reset.
- R7: If the reconfiguration bit is 1 when a session closes, a later write of 16'h2D52 opens a new session.
- R8: Clearing the reconfiguration bit during a later session makes the lock permanent once that session closes.
- R9: A write to the control register while locked leaves the reconfiguration bit unchanged. A wrong key written while locked leaves the state unchanged.
- R10: Writing 16'h2D52 again while a session is open keeps the session open.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hard reset |
| bus_addr | input | AW | Register address |
| bus_wdata | input | DW | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | DW | Read data for key and control registers, zero elsewhere |
| prot_we_o | output | PROT_COUNT | One-hot write enables for the protected registers |
| lock_o | output | 1 | 1 while write access is closed |
| recfg_o | output | 1 | Current reconfiguration bit |

## Verification
The bench builds the block with its default parameters. These are a 4-bit address, 16-bit data, and eight protected slots starting at address 2. With these values, random addresses land on the key register, the control register, every protected slot and six unmapped addresses. Repeated hard resets, each followed by random traffic with a biased share of correct keys, drive the block through fresh, reopenable and permanently sealed lock states many times.

// File: rtl/cfg_lock_pkg.sv
package cfg_lock_pkg;

    typedef enum logic [1:0] {
        LK_FRESH  = 2'd0,
        LK_OPEN   = 2'd1,
        LK_REARM  = 2'd2,
        LK_SEALED = 2'd3
    } lock_state_e;

    typedef struct packed {
        lock_state_e st;
        logic        recfg;
    } lock_regs_t;

    localparam int CTRL_LOCK_BIT  = 0;
    localparam int CTRL_RECFG_BIT = 1;

endpackage

// File: rtl/cfg_lock_decode.sv
module cfg_lock_decode #(
    parameter int          AW         = 4,
    parameter int          DW         = 16,
    parameter int          KEY_ADDR   = 0,
    parameter int          CTRL_ADDR  = 1,
    parameter int          PROT_BASE  = 2,
    parameter int          PROT_COUNT = 8,
    parameter logic [15:0] KEY_OPEN   = 16'h2D52
) (
    input  logic [AW-1:0]         addr_i,
    input  logic [DW-1:0]         wdata_i,
    input  logic                  we_i,
    output logic                  key_sel_o,
    output logic                  ctrl_sel_o,
    output logic                  key_wr_o,
    output logic                  key_match_o,
    output logic                  ctrl_wr_o,
    output logic [PROT_COUNT-1:0] prot_sel_o
);

    localparam logic [AW-1:0] KEY_A  = AW'(KEY_ADDR);
    localparam logic [AW-1:0] CTRL_A = AW'(CTRL_ADDR);
    localparam logic [DW-1:0] KEY_W  = DW'(KEY_OPEN);

    always_comb begin
        key_sel_o   = (addr_i == KEY_A);
        ctrl_sel_o  = (addr_i == CTRL_A);
        key_wr_o    = we_i && key_sel_o;
        ctrl_wr_o   = we_i && ctrl_sel_o;
        key_match_o = (wdata_i == KEY_W);
    end

    for (genvar gi = 0; gi < PROT_COUNT; gi++) begin : g_slot
        localparam logic [AW-1:0] SLOT_A = AW'(PROT_BASE + gi);
        assign prot_sel_o[gi] = (addr_i == SLOT_A);
    end

endmodule

// File: rtl/cfg_lock_fsm.sv
module cfg_lock_fsm
    import cfg_lock_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        key_wr_i,
    input  logic        key_match_i,
    input  logic        ctrl_wr_i,
    input  logic        recfg_wdata_i,
    output lock_state_e st_o,
    output logic        open_o,
    output logic        recfg_o
);

    lock_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        unique case (regs_q.st)
            LK_FRESH, LK_REARM: begin
                if (key_wr_i && key_match_i) regs_d.st = LK_OPEN;
            end
            LK_OPEN: begin
                if (key_wr_i && !key_match_i) begin
                    regs_d.st = regs_q.recfg ? LK_REARM : LK_SEALED;
                end
                if (ctrl_wr_i) regs_d.recfg = recfg_wdata_i;
            end
            LK_SEALED: begin
                regs_d.st = LK_SEALED;
            end
            default: regs_d.st = LK_SEALED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.st    <= LK_FRESH;
            regs_q.recfg <= 1'b0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign st_o    = regs_q.st;
    assign open_o  = (regs_q.st == LK_OPEN);
    assign recfg_o = regs_q.recfg;

endmodule

// File: rtl/cfg_lock_rdmux.sv
module cfg_lock_rdmux
    import cfg_lock_pkg::*;
#(
    parameter int          DW     = 16,
    parameter logic [15:0] KEY_ID = 16'h96A5
) (
    input  logic          key_sel_i,
    input  logic          ctrl_sel_i,
    input  logic          lock_i,
    input  logic          recfg_i,
    output logic [DW-1:0] rdata_o
);

    localparam logic [DW-1:0] ID_W = DW'(KEY_ID);

    always_comb begin
        rdata_o = '0;
        if (key_sel_i) begin
            rdata_o = ID_W;
        end else if (ctrl_sel_i) begin
            rdata_o[CTRL_LOCK_BIT]  = lock_i;
            rdata_o[CTRL_RECFG_BIT] = recfg_i;
        end
    end

endmodule

// File: rtl/cfg_lock_guard.sv
module cfg_lock_guard
    import cfg_lock_pkg::*;
#(
    parameter int          AW         = 4,
    parameter int          DW         = 16,
    parameter int          KEY_ADDR   = 0,
    parameter int          CTRL_ADDR  = 1,
    parameter int          PROT_BASE  = 2,
    parameter int          PROT_COUNT = 8,
    parameter logic [15:0] KEY_OPEN   = 16'h2D52,
    parameter logic [15:0] KEY_ID     = 16'h96A5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [AW-1:0]         bus_addr,
    input  logic [DW-1:0]         bus_wdata,
    input  logic                  bus_we,
    output logic [DW-1:0]         bus_rdata,
    output logic [PROT_COUNT-1:0] prot_we_o,
    output logic                  lock_o,
    output logic                  recfg_o
);

    logic                  key_sel, ctrl_sel, key_wr, key_match, ctrl_wr;
    logic [PROT_COUNT-1:0] prot_sel;
    logic                  sess_open;
    lock_state_e           fsm_st;

    cfg_lock_decode #(
        .AW(AW), .DW(DW), .KEY_ADDR(KEY_ADDR), .CTRL_ADDR(CTRL_ADDR),
        .PROT_BASE(PROT_BASE), .PROT_COUNT(PROT_COUNT), .KEY_OPEN(KEY_OPEN)
    ) u_dec (
        .addr_i     (bus_addr),
        .wdata_i    (bus_wdata),
        .we_i       (bus_we),
        .key_sel_o  (key_sel),
        .ctrl_sel_o (ctrl_sel),
        .key_wr_o   (key_wr),
        .key_match_o(key_match),
        .ctrl_wr_o  (ctrl_wr),
        .prot_sel_o (prot_sel)
    );

    cfg_lock_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .key_wr_i     (key_wr),
        .key_match_i  (key_match),
        .ctrl_wr_i    (ctrl_wr),
        .recfg_wdata_i(bus_wdata[CTRL_RECFG_BIT]),
        .st_o         (fsm_st),
        .open_o       (sess_open),
        .recfg_o      (recfg_o)
    );

    cfg_lock_rdmux #(.DW(DW), .KEY_ID(KEY_ID)) u_rd (
        .key_sel_i (key_sel),
        .ctrl_sel_i(ctrl_sel),
        .lock_i    (lock_o),
        .recfg_i   (recfg_o),
        .rdata_o   (bus_rdata)
    );

    assign lock_o    = !sess_open;
    assign prot_we_o = prot_sel & {PROT_COUNT{bus_we && sess_open}};

endmodule

// File: rtl/cfg_lock_guard_chk.sv
module cfg_lock_guard_chk
    import cfg_lock_pkg::*;
#(
    parameter int          AW         = 4,
    parameter int          DW         = 16,
    parameter int          KEY_ADDR   = 0,
    parameter int          CTRL_ADDR  = 1,
    parameter int          PROT_COUNT = 8,
    parameter logic [15:0] KEY_OPEN   = 16'h2D52,
    parameter logic [15:0] KEY_ID     = 16'h96A5
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [AW-1:0]         bus_addr,
    input logic [DW-1:0]         bus_wdata,
    input logic                  bus_we,
    input logic [DW-1:0]         bus_rdata,
    input logic [PROT_COUNT-1:0] prot_we_o,
    input logic                  lock_o,
    input logic                  recfg_o,
    input lock_state_e           fsm_st
);

    localparam logic [AW-1:0] KA = AW'(KEY_ADDR);
    localparam logic [AW-1:0] CA = AW'(CTRL_ADDR);
    localparam logic [DW-1:0] KO = DW'(KEY_OPEN);
    localparam logic [DW-1:0] KI = DW'(KEY_ID);

    // R4: at most one protected enable, and none while locked
    p_onehot_we_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(prot_we_o));
    p_locked_no_we_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lock_o |-> (prot_we_o == '0));

    // R2: key register reads its fixed identity value
    p_key_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == KA) |-> (bus_rdata == KI));

    // R5: wrong key while open closes the session
    p_wrong_key_closes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock_o && bus_we && bus_addr == KA && bus_wdata != KO) |=> lock_o);

    // R10: correct key while open keeps it open
    p_rekey_stays_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock_o && bus_we && bus_addr == KA && bus_wdata == KO) |=> !lock_o);

    // R9: control writes while locked leave the reconfiguration bit alone
    p_locked_ctrl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_o && bus_we && bus_addr == CA) |=> $stable(recfg_o));

    // R6: a sealed lock never reopens
    p_sealed_stays_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_st == LK_SEALED) |=> (fsm_st == LK_SEALED && lock_o));

    // R8: closing with the bit clear seals the lock
    p_close_seal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock_o && !recfg_o && bus_we && bus_addr == KA && bus_wdata != KO)
        |=> (fsm_st == LK_SEALED));

endmodule

bind cfg_lock_guard cfg_lock_guard_chk #(
    .AW(AW), .DW(DW), .KEY_ADDR(KEY_ADDR), .CTRL_ADDR(CTRL_ADDR),
    .PROT_COUNT(PROT_COUNT), .KEY_OPEN(KEY_OPEN), .KEY_ID(KEY_ID)
) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .prot_we_o(prot_we_o),
    .lock_o(lock_o), .recfg_o(recfg_o), .fsm_st(fsm_st)
);

// File: tb/cfg_lock_guard_tb.sv
module cfg_lock_guard_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 4;
    localparam int DW = 16;
    localparam int NP = 8;
    localparam logic [15:0] K_OPEN = 16'h2D52;
    localparam logic [15:0] K_ID   = 16'h96A5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic          bus_we = 1'b0;
    logic [DW-1:0] bus_rdata;
    logic [NP-1:0] prot_we_o;
    logic          lock_o, recfg_o;

    int total = 0;
    int bad = 0;

    // model: 0 fresh, 1 open, 2 rearmed, 3 sealed
    int m_st = 0;
    bit m_recfg = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_lock_guard dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .prot_we_o(prot_we_o),
        .lock_o(lock_o), .recfg_o(recfg_o)
    );

    function automatic logic [NP-1:0] exp_we(int st, logic we, int a);
        if (st == 1 && we && a >= 2 && a < 2 + NP) return NP'(1) << (a - 2);
        return '0;
    endfunction

    function automatic logic [DW-1:0] exp_rd(int st, bit rc, int a);
        if (a == 0) return K_ID;
        if (a == 1) return {14'd0, rc, (st != 1)};
        return '0;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic model_step(int a, logic [DW-1:0] d, logic we);
        if (!we) return;
        if (a == 0) begin
            if (d == K_OPEN) begin
                if (m_st != 3) m_st = 1;
            end else if (m_st == 1) begin
                m_st = m_recfg ? 2 : 3;
            end
        end else if (a == 1 && m_st == 1) begin
            m_recfg = d[1];
        end
    endtask

    // one bus cycle: drive at negedge, check comb, clock, check state
    task automatic op(int a, logic [DW-1:0] d, logic we, string tag);
        bus_addr = AW'(a);
        bus_wdata = d;
        bus_we = we;
        #1;
        chk({tag, " R4 we"}, 32'(prot_we_o), 32'(exp_we(m_st, we, a)));
        chk({tag, " R2 rdata"}, 32'(bus_rdata), 32'(exp_rd(m_st, m_recfg, a)));
        @(posedge clk);
        model_step(a, d, we);
        @(negedge clk);
        bus_we = 1'b0;
        chk({tag, " lock"}, 32'(lock_o), 32'(m_st != 1));
        chk({tag, " recfg"}, 32'(recfg_o), 32'(m_recfg));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        bus_we = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_st = 0;
        m_recfg = 1'b0;
        #1;
        chk("R1 lock", 32'(lock_o), 32'd1);
        chk("R1 recfg", 32'(recfg_o), 32'd0);
        chk("R1 we", 32'(prot_we_o), 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));

        // directed: single session then permanent lock
        do_reset();
        op(0, 16'h1234, 1'b1, "R9 wrong key locked");
        op(1, 16'h0002, 1'b1, "R9 ctrl while locked");
        op(3, 16'h0000, 1'b1, "R4 locked write");
        op(0, K_OPEN, 1'b1, "R3 open");
        op(5, 16'h0000, 1'b1, "R4 open write");
        op(0, K_OPEN, 1'b1, "R10 rekey");
        op(9, 16'h0000, 1'b1, "R4 last slot");
        op(10, 16'h0000, 1'b1, "R4 past window");
        op(0, 16'h0000, 1'b1, "R5 close");
        op(0, K_OPEN, 1'b1, "R6 reopen refused");
        op(1, 16'h0000, 1'b0, "R2 ctrl read");

        // directed: reconfiguration allowed, then cleared
        do_reset();
        op(0, K_OPEN, 1'b1, "R3 open");
        op(1, 16'h0002, 1'b1, "R7 set recfg");
        op(0, 16'hFFFF, 1'b1, "R5 close");
        op(1, 16'h0000, 1'b1, "R9 ctrl locked");
        op(0, K_OPEN, 1'b1, "R7 reopen");
        op(1, 16'h0000, 1'b1, "R8 clear recfg");
        op(0, 16'h0001, 1'b1, "R8 close");
        op(0, K_OPEN, 1'b1, "R8 reopen refused");
        op(2, 16'h0000, 1'b1, "R8 no write");

        // constrained random
        for (int run = 0; run < 10; run++) begin
            do_reset();
            for (int n = 0; n < 400; n++) begin
                int a;
                logic [DW-1:0] d;
                int r;
                r = int'($urandom_range(0, 99));
                if (r < 25) a = 0;
                else if (r < 40) a = 1;
                else a = int'($urandom_range(0, 15));
                d = DW'($urandom);
                if (a == 0 && $urandom_range(0, 99) < 55) d = K_OPEN;
                if (a == 0 && $urandom_range(0, 99) < 85 - run * 8) d = K_OPEN;
                op(a, d, 1'($urandom_range(0, 3) != 0), "rand R4 R5 R6 R7 R8");
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule